// File: doc/BRIEF.md
# Grouped Interrupt Mask and Summary Unit

This unit collects single-cycle event pulses from surrounding datapath logic into sticky status flags. Each flag is paired with an enable flag at the same bit position. Every source belongs to one of two classes. The abnormal class is for error and stall conditions, and the normal class is for completed work. The unit combines each flag with its enable, reduces each class to one summary bit, and gates each summary with its own class enable. The result is a single interrupt request line.

Software reaches the unit through a minimal register port with one write strobe and a one-bit register select. Select 0 is the status register and select 1 is the enable register. Read data is combinational and follows the select. Status flags are cleared by writing ones to them. The enable register is written directly.

Top module: `intr_sum_top`

## Requirements
- R1: After reset every status flag and every enable flag is 0, both registers read back as zero, and `irqOut` is low.
- R2: An `eventIn` pulse at a source position sets that status flag on the next clock edge. The flag stays set until software clears it. Source positions are bits 5, 7, 8, 9, 11 and 13 (abnormal) and bits 6 and 10 (normal).
- R3: A write to the status register (select 0) clears every source flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: If an event pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R5: Status read bit 15 is the abnormal summary. It is 1 exactly when some abnormal source has both its status flag and its enable flag set.
- R6: Status read bit 16 is the normal summary. It is 1 exactly when source 6 or source 10 has both its status flag and its enable flag set.
- R7: `irqOut` is high exactly when (abnormal summary AND enable bit 15) OR (normal summary AND enable bit 16).
- R8: Status bits outside the source and summary positions, including the reserved bits 12 and 14, always read 0. Event pulses on those positions have no effect on the read data or on `irqOut`.
- R9: A write to the enable register (select 1) stores the data bits at the source positions and at bits 15 and 16. Every other enable bit reads 0.
- R10: Summary bits 15 and 16 in the status register cannot be set or cleared by a write. They only follow the source flags and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 enable |
| regWrData | input | 32 | Write data |
| eventIn | input | 32 | Event pulses, one bit per source position |
| rdData | output | 32 | Combinational read data of the selected register |
| irqOut | output | 1 | Interrupt request |

## Verification
A wrong flag value inside the unit is visible on the port in the cycle after the faulty update. It appears in the status readback, where a summary bit that depends on it can also flip, and `irqOut` changes in that same cycle. A dropped or stuck enable shows in the enable readback at once. An enable that is stored correctly but used wrongly only shows when a matching status flag is set, so the reference model is compared after every edge, across sparse and dense event and enable patterns.

// File: rtl/intr_sum_pkg.sv
package intr_sum_pkg;

  localparam int REG_W = 32;

  // Default class membership by bit position
  localparam logic [REG_W-1:0] ABN_SRC_DEF = 32'h0000_2BA0;  // 5,7,8,9,11,13
  localparam logic [REG_W-1:0] NRM_SRC_DEF = 32'h0000_0440;  // 6,10
  localparam int ABN_POS_DEF = 15;
  localparam int NRM_POS_DEF = 16;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } regSel_t;

  typedef struct packed {
    logic             stsClr;   // clear-on-one write to status
    logic             enLoad;   // load enable register
    logic [REG_W-1:0] wrBits;   // write data, already masked
  } ctrlStrb_t;

endpackage

// File: rtl/intr_sum_ctrl.sv
module intr_sum_ctrl
  import intr_sum_pkg::*;
#(
  parameter logic [REG_W-1:0] ABN_MASK = ABN_SRC_DEF,
  parameter logic [REG_W-1:0] NRM_MASK = NRM_SRC_DEF,
  parameter int               ABN_POS  = ABN_POS_DEF,
  parameter int               NRM_POS  = NRM_POS_DEF
) (
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output ctrlStrb_t        strb
);

  localparam logic [REG_W-1:0] SRC_MASK = ABN_MASK | NRM_MASK;
  localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK
                                        | (REG_W'(1) << ABN_POS)
                                        | (REG_W'(1) << NRM_POS);

  regSel_t sel;

  always_comb begin
    sel         = regSel_t'(regAddr);
    strb.stsClr = regWr && (sel == SEL_STATUS);
    strb.enLoad = regWr && (sel == SEL_ENABLE);
    // summary and reserved positions never reach the status flops
    if (sel == SEL_STATUS) strb.wrBits = regWrData & SRC_MASK;
    else                   strb.wrBits = regWrData & EN_MASK;
  end

endmodule

// File: rtl/intr_sum_dp.sv
module intr_sum_dp
  import intr_sum_pkg::*;
#(
  parameter logic [REG_W-1:0] ABN_MASK = ABN_SRC_DEF,
  parameter logic [REG_W-1:0] NRM_MASK = NRM_SRC_DEF,
  parameter int               ABN_POS  = ABN_POS_DEF,
  parameter int               NRM_POS  = NRM_POS_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [REG_W-1:0] eventIn,
  input  logic             regAddr,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] stsQ,
  output logic [REG_W-1:0] enQ,
  output logic             irqOut
);

  localparam logic [REG_W-1:0] SRC_MASK = ABN_MASK | NRM_MASK;
  localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK
                                        | (REG_W'(1) << ABN_POS)
                                        | (REG_W'(1) << NRM_POS);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    // status flag: only at source positions
    if (SRC_MASK[i]) begin : g_sts
      logic flagQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               flagQ <= 1'b0;
        else if (eventIn[i])                     flagQ <= 1'b1;  // set wins
        else if (strb.stsClr && strb.wrBits[i])  flagQ <= 1'b0;
      end
      assign stsQ[i] = flagQ;
    end else begin : g_stsNone
      assign stsQ[i] = 1'b0;
    end

    // enable flag: sources plus the two class enables
    if (EN_MASK[i]) begin : g_en
      logic enBitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            enBitQ <= 1'b0;
        else if (strb.enLoad) enBitQ <= strb.wrBits[i];
      end
      assign enQ[i] = enBitQ;
    end else begin : g_enNone
      assign enQ[i] = 1'b0;
    end
  end

  logic [REG_W-1:0] armed;
  logic             abnHit;
  logic             nrmHit;
  logic [REG_W-1:0] stsView;

  always_comb begin
    armed   = stsQ & enQ;
    abnHit  = |(armed & ABN_MASK);
    nrmHit  = |(armed & NRM_MASK);
    irqOut  = (abnHit && enQ[ABN_POS]) || (nrmHit && enQ[NRM_POS]);
    stsView = stsQ;
    stsView[ABN_POS] = abnHit;
    stsView[NRM_POS] = nrmHit;
    rdData  = (regSel_t'(regAddr) == SEL_ENABLE) ? enQ : stsView;
  end

endmodule

// File: rtl/intr_sum_top.sv
module intr_sum_top
  import intr_sum_pkg::*;
#(
  parameter logic [REG_W-1:0] ABN_MASK = ABN_SRC_DEF,
  parameter logic [REG_W-1:0] NRM_MASK = NRM_SRC_DEF,
  parameter int               ABN_POS  = ABN_POS_DEF,
  parameter int               NRM_POS  = NRM_POS_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [REG_W-1:0] eventIn,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);

  ctrlStrb_t        strb;
  logic [REG_W-1:0] stsQ;
  logic [REG_W-1:0] enQ;

  intr_sum_ctrl #(
    .ABN_MASK(ABN_MASK), .NRM_MASK(NRM_MASK),
    .ABN_POS(ABN_POS),   .NRM_POS(NRM_POS)
  ) u_ctrl (
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  intr_sum_dp #(
    .ABN_MASK(ABN_MASK), .NRM_MASK(NRM_MASK),
    .ABN_POS(ABN_POS),   .NRM_POS(NRM_POS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .eventIn (eventIn),
    .regAddr (regAddr),
    .rdData  (rdData),
    .stsQ    (stsQ),
    .enQ     (enQ),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/intr_sum_chk.sv
module intr_sum_chk
  import intr_sum_pkg::*;
#(
  parameter logic [REG_W-1:0] ABN_MASK = ABN_SRC_DEF,
  parameter logic [REG_W-1:0] NRM_MASK = NRM_SRC_DEF,
  parameter int               ABN_POS  = ABN_POS_DEF,
  parameter int               NRM_POS  = NRM_POS_DEF
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic             regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] eventIn,
  input logic [REG_W-1:0] rdData,
  input logic             irqOut,
  input logic [REG_W-1:0] stsQ,
  input logic [REG_W-1:0] enQ
);

  localparam logic [REG_W-1:0] SRC_MASK = ABN_MASK | NRM_MASK;
  localparam logic [REG_W-1:0] VIS_MASK = SRC_MASK
                                        | (REG_W'(1) << ABN_POS)
                                        | (REG_W'(1) << NRM_POS);

  // one full clock out of reset before looking at $past
  logic armQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armQ <= 1'b0;
    else       armQ <= 1'b1;
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> ((($past(eventIn) & SRC_MASK) & ~stsQ) == '0)); // R4

  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && $past(regWr) && !$past(regAddr))
      |-> ((stsQ & $past(regWrData) & ~$past(eventIn) & SRC_MASK) == '0)); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (armQ && !($past(regWr) && !$past(regAddr)))
      |-> (($past(stsQ) & ~stsQ) == '0)); // R2

  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((stsQ & enQ & SRC_MASK) != '0)); // R7

  AST_IRQ_NEEDS_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ[ABN_POS] && !enQ[NRM_POS]) |-> !irqOut); // R7

  AST_READ_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~VIS_MASK) == '0); // R8

endmodule

bind intr_sum_top intr_sum_chk #(
  .ABN_MASK(ABN_MASK), .NRM_MASK(NRM_MASK),
  .ABN_POS(ABN_POS),   .NRM_POS(NRM_POS)
) u_chk (.*);

// File: tb/test_intr_sum_top.sv
`timescale 1ns/1ps
module test_intr_sum_top;

  localparam logic [31:0] ABN = 32'h0000_2BA0;
  localparam logic [31:0] NRM = 32'h0000_0440;
  localparam logic [31:0] SRC = ABN | NRM;
  localparam logic [31:0] ENW = SRC | 32'h0001_8000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] eventIn = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  logic [31:0] mSts = '0;
  logic [31:0] mEn = '0;

  always #10 clk = ~clk;

  intr_sum_top i_intr_sum_top (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .eventIn(eventIn), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic abnSum();
    return |(mSts & mEn & ABN);
  endfunction
  function automatic logic nrmSum();
    return |(mSts & mEn & NRM);
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // called at a negedge: look at both registers and the request line
  task automatic compareAll(input string tag);
    logic [31:0] expSts;
    expSts = (mSts & SRC) | ({31'b0, abnSum()} << 15) | ({31'b0, nrmSum()} << 16);
    regAddr = 1'b0; #1;
    chk(rdData, expSts, tag);
    regAddr = 1'b1; #1;
    chk(rdData, mEn, {tag, " R9"});
    chk({31'b0, irqOut},
        {31'b0, (abnSum() && mEn[15]) || (nrmSum() && mEn[16])}, {tag, " R7"});
  endtask

  task automatic step(input logic wr, input logic addr, input logic [31:0] d,
                      input logic [31:0] ev, input string tag);
    regWr = wr; regAddr = addr; regWrData = d; eventIn = ev;
    @(posedge clk);
    if (wr && !addr) mSts = mSts & ~d;
    mSts = (mSts | ev) & SRC;
    if (wr && addr) mEn = d & ENW;
    @(negedge clk);
    regWr = 1'b0; eventIn = '0; regWrData = '0;
    compareAll(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");

    // R2: each source sets and stays
    step(1'b0, 1'b0, '0, 32'h0000_0020, "R2 bit5");
    step(1'b0, 1'b0, '0, 32'h0000_0400, "R2 bit10");
    step(1'b0, 1'b0, '0, '0, "R2 hold");
    step(1'b0, 1'b0, '0, SRC, "R2 all");
    // R5 R6: summaries with individual enables only
    step(1'b1, 1'b1, 32'h0000_0080, '0, "R5 one abn enable");
    step(1'b1, 1'b1, 32'h0000_0040, '0, "R6 one nrm enable");
    // R7: class enables
    step(1'b1, 1'b1, 32'h0000_8080, '0, "R7 abn class on");
    step(1'b1, 1'b1, 32'h0001_0040, '0, "R7 nrm class on");
    step(1'b1, 1'b1, 32'h0001_0080, '0, "R7 mismatch class");
    // R3: partial clear
    step(1'b1, 1'b0, 32'h0000_0041, '0, "R3 clear bit6");
    step(1'b1, 1'b0, '0, '0, "R3 zero write");
    // R10: writes to summary positions
    step(1'b1, 1'b1, 32'h0001_8FFF, '0, "R10 setup");
    step(1'b1, 1'b0, 32'h0001_8000, '0, "R10 write summary bits");
    // R4: set beats clear
    step(1'b1, 1'b0, SRC, 32'h0000_0200, "R4 same cycle");
    step(1'b1, 1'b0, SRC, '0, "R3 clear all");
    // R8: reserved positions
    step(1'b0, 1'b0, '0, ~SRC, "R8 reserved events");
    step(1'b1, 1'b1, 32'hFFFF_FFFF, '0, "R8 enable all ones");
    step(1'b0, 1'b0, '0, 32'h0000_5000, "R8 bits 12 14");
    step(1'b0, 1'b0, '0, 32'h0000_2000, "R5 bit13 fatal");

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rnd;
      logic [31:0] ev;
      rnd = $urandom;
      ev  = ((rnd[3:0] == 4'd0) ? $urandom : 32'h0) & (($urandom % 3 == 0) ? 32'hFFFF_FFFF : SRC);
      case (rnd[6:4])
        3'd0:    step(1'b1, 1'b1, $urandom, ev, "R7 mixed enable");
        3'd1:    step(1'b1, 1'b0, $urandom, ev, "R3 mixed clear");
        3'd2:    step(1'b1, 1'b0, $urandom, $urandom, "R4 mixed");
        default: step(1'b0, rnd[7], $urandom, ev, "R2 mixed");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule